// File: doc/BRIEF.md
# CEC Transmit Frame Staging Unit

This block holds one outgoing CEC frame in a small bank of host-writable registers and feeds it, one byte at a time, to a bit-level CEC transmitter. The host fills in the initiator and destination logical addresses, the opcode and up to `MAX_OPS` operand bytes. A start write then launches the frame. A polling frame consists of the header byte only. It is launched by setting the top bit of the destination write, and in that case the opcode and the operands are left out.

The transmitter reports the outcome of every attempt. The possible outcomes are acknowledged, not acknowledged, or arbitration lost. On a negative acknowledge the block resends the whole frame, starting from the header, until the programmed retry limit is used up. At that point it raises a NACK event, and the number of retries it used can be read back. When arbitration is lost, the block raises its own event and does not retry. A self-clearing flush bit cancels any frame that is in flight.

Top module: `cec_tx_stage`

## Requirements
- R1: After reset, `busy`, `tx_valid` and all three event outputs are low, and the control register (word 0) reads as 0.
- R2: A started frame presents its bytes on `tx_byte` in this order: header `{initiator[3:0], destination[3:0]}`, then the opcode, then operands 0 to n-1. `tx_last` is set only on the final byte. A byte is held until `tx_ready` is high.
- R3: A write to the start register (word 4) starts a frame only if bit 4 is set. Bits 3:0 give the operand count, and any count above `MAX_OPS` (14) is reduced to 14.
- R4: A write to the destination register (word 2) with bit 7 set stores bits 3:0 as the destination and starts a one-byte polling frame. Its single header byte carries `tx_last`.
- R5: When an attempt ends with a NACK and retries remain, the frame is resent from the header. A frame makes at most limit+1 attempts, where the limit is written through control bits 6:4 while the block is idle.
- R6: The outcomes raise one-cycle event pulses. An ACK raises `evt_ok`. A NACK after the last allowed attempt raises `evt_nack`. Arbitration loss raises `evt_arb` at once, with no retry. Control bits 6:4 read the number of retries used in the last frame.
- R7: While `busy` is high, writes to the staging registers, to the retry limit and to either start control are ignored. The frame in flight and the register contents stay unchanged.
- R8: Writing 1 to control bit 7 starts a flush. Bit 7 reads 1 for `FLUSH_CYC` cycles and then clears itself. The flush aborts a frame in progress without raising any event.
- R9: The initiator (word 1), destination (word 2), opcode (word 3) and operand i (word 8+i) read back the values that were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 5 | Register word index |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_byte | output | 8 | Byte being offered |
| tx_last | output | 1 | Offered byte ends the frame |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| res_valid | input | 1 | Attempt outcome is present |
| res_ack | input | 1 | Attempt was acknowledged |
| res_arb | input | 1 | Attempt lost arbitration |
| busy | output | 1 | A frame is in progress |
| evt_ok | output | 1 | Frame acknowledged (pulse) |
| evt_nack | output | 1 | Retries exhausted after NACK (pulse) |
| evt_arb | output | 1 | Arbitration lost (pulse) |

## Verification
The embedded assertions check the following on every cycle: at most one event pulse at a time, the retry counter never passing the limit, a stalled byte staying stable, the byte index staying inside the frame, a flush forcing the block idle, and the opcode register being frozen while the block is busy. Only the bench scenarios can show the exact byte order and count across every operand count from 0 to 15, the clamp, polling frames, the number of attempts for each retry limit from 0 to 7, the retries-used readback, and the fact that a second start write during a busy frame is ignored.

// File: rtl/cec_stg_pkg.sv
// Package: register word indices and sequencer state type shared by the
// CEC transmit staging modules.
package cec_stg_pkg;
    localparam int AW = 5;
    localparam logic [AW-1:0] A_CTRL = 5'd0;
    localparam logic [AW-1:0] A_INIT = 5'd1;
    localparam logic [AW-1:0] A_DEST = 5'd2;
    localparam logic [AW-1:0] A_OPC  = 5'd3;
    localparam logic [AW-1:0] A_TXD  = 5'd4;
    localparam logic [AW-1:0] A_OPR0 = 5'd8;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SEND,
        S_WAIT
    } seq_st_t;
endpackage

// File: rtl/cec_stg_regs.sv
// Register bank for the staged frame. It holds the addresses, the opcode, the
// operands, the clamped operand count and the retry limit, runs the
// self-clearing flush counter and decodes the two start writes.
// Assumes: MAX_OPS + 8 fits in the 5-bit word index, and busy comes from the
// sequencer. Staging writes are dropped while busy.
module cec_stg_regs
    import cec_stg_pkg::*;
#(
    parameter int MAX_OPS   = 14,
    parameter int FLUSH_CYC = 8,
    localparam int CW = $clog2(MAX_OPS + 1),
    localparam int FW = $clog2(FLUSH_CYC + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [7:0]               wdata,
    input  logic                     busy,
    input  logic [2:0]               retries_used,
    output logic [7:0]               rdata,
    output logic [3:0]               init_q,
    output logic [3:0]               dest_q,
    output logic [7:0]               opc_q,
    output logic [MAX_OPS-1:0][7:0]  opr_q,
    output logic [CW-1:0]            nops_q,
    output logic [2:0]               limit_q,
    output logic                     flush_active,
    output logic                     start_full,
    output logic                     start_poll
);
    logic [FW-1:0] flush_cnt;
    logic          stage_we;
    logic [CW-1:0] nops_d;

    assign flush_active = (flush_cnt != '0);
    assign stage_we     = we && !busy && !flush_active;
    assign start_full   = stage_we && (addr == A_TXD) && wdata[4];
    assign start_poll   = stage_we && (addr == A_DEST) && wdata[7];

    // Clamp the requested operand count to the staging depth.
    always_comb begin
        if (int'(wdata[3:0]) > MAX_OPS) nops_d = CW'(MAX_OPS);
        else                            nops_d = CW'(wdata[3:0]);
    end

    // Scalar staging registers and retry limit, written only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q  <= '0;
            dest_q  <= '0;
            opc_q   <= '0;
            nops_q  <= '0;
            limit_q <= '0;
        end else if (stage_we) begin
            case (addr)
                A_INIT: init_q  <= wdata[3:0];
                A_DEST: dest_q  <= wdata[3:0];
                A_OPC:  opc_q   <= wdata;
                A_TXD:  nops_q  <= nops_d;
                A_CTRL: limit_q <= wdata[6:4];
                default: ;
            endcase
        end
    end

    // One register per operand slot, each decoded from its own word index.
    for (genvar g = 0; g < MAX_OPS; g++) begin : g_opr
        always_ff @(posedge clk) begin
            if (!rst_n)                                       opr_q[g] <= '0;
            else if (stage_we && addr == A_OPR0 + AW'(g))     opr_q[g] <= wdata;
        end
    end

    // Flush countdown: loaded by a control write with bit 7, counts to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        flush_cnt <= '0;
        else if (we && addr == A_CTRL && wdata[7] && !flush_active)
                                                           flush_cnt <= FW'(FLUSH_CYC);
        else if (flush_active)                             flush_cnt <= flush_cnt - 1'b1;
    end

    // Combinational readback of the register bank.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: rdata = {flush_active, retries_used, 4'b0};
            A_INIT: rdata = {4'b0, init_q};
            A_DEST: rdata = {4'b0, dest_q};
            A_OPC:  rdata = opc_q;
            A_TXD:  rdata = 8'(nops_q);
            default: begin
                for (int k = 0; k < MAX_OPS; k++)
                    if (addr == A_OPR0 + AW'(k)) rdata = opr_q[k];
            end
        endcase
    end

    // R7: the opcode cannot change under a frame in flight.
    a_r7_opc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && we && addr == A_OPC) |=> $stable(opc_q));

    // R8: a flush, once running, holds for its length and never reloads early.
    a_r8_flush_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        flush_active |=> (flush_cnt == $past(flush_cnt) - 1'b1));
endmodule

// File: rtl/cec_stg_seq.sv
// Frame sequencer. It walks the header, opcode and operand bytes over a
// valid/ready byte interface, waits for the outcome of each attempt, resends
// on NACK up to the retry limit and pulses one event per finished frame.
// Assumes: the staging inputs stay stable while busy, and an outcome is
// reported only after the last byte has been taken.
module cec_stg_seq
    import cec_stg_pkg::*;
#(
    parameter int MAX_OPS = 14,
    localparam int CW = $clog2(MAX_OPS + 1),
    localparam int NW = $clog2(MAX_OPS + 3)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_full,
    input  logic                     start_poll,
    input  logic                     flush_active,
    input  logic [3:0]               init_q,
    input  logic [3:0]               dest_q,
    input  logic [7:0]               opc_q,
    input  logic [MAX_OPS-1:0][7:0]  opr_q,
    input  logic [CW-1:0]            nops_q,
    input  logic [2:0]               limit_q,
    input  logic                     tx_ready,
    input  logic                     res_valid,
    input  logic                     res_ack,
    input  logic                     res_arb,
    output logic                     tx_valid,
    output logic [7:0]               tx_byte,
    output logic                     tx_last,
    output logic                     busy,
    output logic [2:0]               retries_used,
    output logic                     evt_ok,
    output logic                     evt_nack,
    output logic                     evt_arb
);
    seq_st_t       st;
    logic [NW-1:0] idx;
    logic [NW-1:0] nbytes;
    logic          poll_q;
    logic [2:0]    rcnt;

    assign nbytes       = poll_q ? NW'(1) : NW'(nops_q) + NW'(2);
    assign tx_valid     = (st == S_SEND);
    assign tx_last      = tx_valid && (idx == nbytes - 1'b1);
    assign busy         = (st != S_IDLE);
    assign retries_used = rcnt;

    // Select the byte at the current frame position.
    always_comb begin
        tx_byte = {init_q, dest_q};
        if (idx == NW'(1)) tx_byte = opc_q;
        for (int k = 0; k < MAX_OPS; k++)
            if (idx == NW'(k + 2)) tx_byte = opr_q[k];
    end

    // Frame state, byte position, retry count and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            idx      <= '0;
            poll_q   <= 1'b0;
            rcnt     <= '0;
            evt_ok   <= 1'b0;
            evt_nack <= 1'b0;
            evt_arb  <= 1'b0;
        end else begin
            evt_ok   <= 1'b0;
            evt_nack <= 1'b0;
            evt_arb  <= 1'b0;
            if (flush_active) begin
                st  <= S_IDLE;
                idx <= '0;
            end else begin
                case (st)
                    S_IDLE: if (start_full || start_poll) begin
                        st     <= S_SEND;
                        idx    <= '0;
                        poll_q <= start_poll;
                        rcnt   <= '0;
                    end
                    S_SEND: if (tx_ready) begin
                        if (tx_last) st  <= S_WAIT;
                        else         idx <= idx + 1'b1;
                    end
                    S_WAIT: if (res_valid) begin
                        if (res_arb) begin
                            evt_arb <= 1'b1;
                            st      <= S_IDLE;
                        end else if (res_ack) begin
                            evt_ok <= 1'b1;
                            st     <= S_IDLE;
                        end else if (rcnt == limit_q) begin
                            evt_nack <= 1'b1;
                            st       <= S_IDLE;
                        end else begin
                            rcnt <= rcnt + 1'b1;
                            idx  <= '0;
                            st   <= S_SEND;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R6: outcomes are mutually exclusive.
    a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_ok, evt_nack, evt_arb}));

    // R6: exhausted NACK reports the full retry allowance as used.
    a_r6_nack_count: assert property (@(posedge clk) disable iff (!rst_n)
        evt_nack |-> (retries_used == limit_q));

    // R5: retries never pass the programmed limit.
    a_r5_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rcnt <= limit_q));

    // R2: an offered byte lies inside the frame and holds while stalled.
    a_r2_idx_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (idx < nbytes));
    a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !flush_active) |=> (tx_valid && $stable(tx_byte)));

    // R8: a flush leaves the sequencer idle.
    a_r8_flush_idles: assert property (@(posedge clk) disable iff (!rst_n)
        flush_active |=> !busy);
endmodule

// File: rtl/cec_tx_stage.sv
// Top of the CEC transmit staging unit: the register bank plus the frame
// sequencer. Assumes a single host writer and a byte transmitter that reports
// one outcome per attempt.
module cec_tx_stage
    import cec_stg_pkg::*;
#(
    parameter int MAX_OPS   = 14,
    parameter int FLUSH_CYC = 8,
    localparam int CW = $clog2(MAX_OPS + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [4:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic        res_valid,
    input  logic        res_ack,
    input  logic        res_arb,
    output logic        busy,
    output logic        evt_ok,
    output logic        evt_nack,
    output logic        evt_arb
);
    logic [3:0]              init_q, dest_q;
    logic [7:0]              opc_q;
    logic [MAX_OPS-1:0][7:0] opr_q;
    logic [CW-1:0]           nops_q;
    logic [2:0]              limit_q, retries_used;
    logic                    flush_active, start_full, start_poll;

    cec_stg_regs #(.MAX_OPS(MAX_OPS), .FLUSH_CYC(FLUSH_CYC)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr),
        .wdata(host_wdata), .busy(busy), .retries_used(retries_used),
        .rdata(host_rdata), .init_q(init_q), .dest_q(dest_q), .opc_q(opc_q),
        .opr_q(opr_q), .nops_q(nops_q), .limit_q(limit_q),
        .flush_active(flush_active), .start_full(start_full),
        .start_poll(start_poll)
    );

    cec_stg_seq #(.MAX_OPS(MAX_OPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_full(start_full),
        .start_poll(start_poll), .flush_active(flush_active),
        .init_q(init_q), .dest_q(dest_q), .opc_q(opc_q), .opr_q(opr_q),
        .nops_q(nops_q), .limit_q(limit_q), .tx_ready(tx_ready),
        .res_valid(res_valid), .res_ack(res_ack), .res_arb(res_arb),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .busy(busy), .retries_used(retries_used), .evt_ok(evt_ok),
        .evt_nack(evt_nack), .evt_arb(evt_arb)
    );
endmodule

// File: tb/cec_tx_stage_tb.sv
// Bench: sweeps operand counts, retry limits, outcomes, polling, busy-time
// writes and flush, with expected bytes computed from the requirements.
module cec_tx_stage_tb;
    localparam int MAXO = 14;
    localparam int FLC  = 8;

    logic clk = 0, rst_n = 0;
    logic host_we = 0;
    logic [4:0] host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic tx_valid, tx_last, busy, evt_ok, evt_nack, evt_arb;
    logic [7:0] tx_byte;
    logic tx_ready = 0, res_valid = 0, res_ack = 0, res_arb = 0;

    int n_chk = 0, n_fail = 0;
    int rdy_mode = 0;
    logic [7:0] cap [256];
    logic       capl [256];
    int ncap = 0, nlast = 0, c_ok = 0, c_nack = 0, c_arb = 0;
    bit done = 0;

    cec_tx_stage #(.MAX_OPS(MAXO), .FLUSH_CYC(FLC)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_last(tx_last), .tx_ready(tx_ready),
        .res_valid(res_valid), .res_ack(res_ack), .res_arb(res_arb),
        .busy(busy), .evt_ok(evt_ok), .evt_nack(evt_nack), .evt_arb(evt_arb)
    );

    always #2 clk = ~clk;

    // Transmitter model: capture accepted bytes and count events.
    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            cap[ncap]  = tx_byte;
            capl[ncap] = tx_last;
            ncap++;
            if (tx_last) nlast++;
        end
        if (evt_ok)   c_ok++;
        if (evt_nack) c_nack++;
        if (evt_arb)  c_arb++;
    end

    // Ready pattern: 0 always, 1 alternating, 2 never.
    always @(negedge clk)
        tx_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ~tx_ready : 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    function automatic logic [7:0] opv(int i, int s);
        return 8'(i * 17 + s * 3 + 1);
    endfunction

    task automatic stage(input int s, input int nwrite);
        wr(5'd1, 8'(s % 15));
        wr(5'd2, 8'((s + 7) % 16));
        wr(5'd3, 8'(s * 5 + 64));
        for (int i = 0; i < nwrite; i++) wr(5'(8 + i), opv(i, s));
    endtask

    // outcome: 0 ack, 1 nack always, 2 arb lost, 3 nack once then ack
    task automatic frame(input int nraw, input bit poll, input int lim,
                         input int outcome, input int s, input string tag);
        int n, nb, att, exp_r, o0, o1, o2, bad;
        logic [7:0] e, r;
        n  = (nraw > MAXO) ? MAXO : nraw;
        nb = poll ? 1 : n + 2;
        att = (outcome == 1) ? lim + 1 : (outcome == 3) ? 2 : 1;
        exp_r = att - 1;
        wr(5'd0, 8'(lim << 4));
        stage(s, MAXO);
        ncap = 0; nlast = 0;
        o0 = c_ok; o1 = c_nack; o2 = c_arb;
        if (poll) wr(5'd2, 8'(8'h80 | ((s + 7) % 16)));
        else      wr(5'd4, 8'(8'h10 | nraw));
        for (int a = 0; a < att; a++) begin
            while (nlast <= a) @(negedge clk);
            @(negedge clk);
            res_valid = 1;
            res_ack = (outcome == 0) || (outcome == 3 && a == 1);
            res_arb = (outcome == 2);
            @(negedge clk);
            res_valid = 0; res_ack = 0; res_arb = 0;
        end
        repeat (2) @(negedge clk);
        bad = -1;
        for (int j = 0; j < ncap; j++) begin
            int p = j % nb;
            e = (p == 0) ? {4'(s % 15), 4'((s + 7) % 16)} :
                (p == 1) ? 8'(s * 5 + 64) : opv(p - 2, s);
            if (bad < 0 && (cap[j] !== e || capl[j] !== (p == nb - 1))) bad = j;
        end
        chk(ncap == nb * att, {tag, " byte count"}, ncap, nb * att);
        chk(bad < 0, {tag, " byte order/last"}, bad, -1);
        chk(busy == 0, {tag, " idle after"}, busy, 0);
        chk(c_ok - o0 == ((outcome == 0 || outcome == 3) ? 1 : 0), "R6 ok event", c_ok - o0, 0);
        chk(c_nack - o1 == (outcome == 1 ? 1 : 0), "R6 nack event", c_nack - o1, 0);
        chk(c_arb - o2 == (outcome == 2 ? 1 : 0), "R6 arb event", c_arb - o2, 0);
        rd(5'd0, r);
        chk(r[6:4] == 3'(exp_r), "R6 retries used readback", r[6:4], exp_r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int o0, o1, o2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && tx_valid == 0, "R1 idle after reset", busy, 0);
        chk(!evt_ok && !evt_nack && !evt_arb, "R1 no events", evt_ok, 0);
        rd(5'd0, r);
        chk(r == 0, "R1 control reads 0", r, 0);

        // R9 readback
        wr(5'd1, 8'h0A); rd(5'd1, r); chk(r == 8'h0A, "R9 initiator", r, 8'h0A);
        wr(5'd2, 8'h05); rd(5'd2, r); chk(r == 8'h05, "R9 destination", r, 8'h05);
        wr(5'd3, 8'hC3); rd(5'd3, r); chk(r == 8'hC3, "R9 opcode", r, 8'hC3);
        wr(5'd21, 8'h9E); rd(5'd21, r); chk(r == 8'h9E, "R9 operand 13", r, 8'h9E);

        // R3 no start without bit 4
        wr(5'd4, 8'h03);
        repeat (4) @(negedge clk);
        chk(busy == 0 && ncap == 0, "R3 no start without bit4", busy, 0);

        // R2/R3 sweep over all operand counts, both ready patterns
        for (int n = 0; n < 16; n++) begin
            rdy_mode = n % 2;
            frame(n, 0, 0, 0, n + 1, (n > MAXO) ? "R3 clamp" : "R2 frame");
        end
        rdy_mode = 0;
        // R5 retry limits 0..7 with persistent NACK
        for (int l = 0; l < 8; l++) frame(3, 0, l, 1, l + 20, "R5 retries");
        frame(5, 0, 3, 3, 30, "R5 nack then ack");
        frame(7, 0, 5, 2, 31, "R6 arb no retry");
        // R4 polling frames
        rdy_mode = 1;
        frame(0, 1, 0, 0, 40, "R4 poll ack");
        frame(0, 1, 2, 1, 41, "R4 poll nack");
        rdy_mode = 0;

        // R7 writes while busy are ignored
        wr(5'd0, 8'h00);
        stage(50, MAXO);
        rdy_mode = 2;
        ncap = 0; nlast = 0;
        wr(5'd4, 8'h12);
        repeat (2) @(negedge clk);
        wr(5'd3, 8'hEE);
        wr(5'd8, 8'h55);
        wr(5'd4, 8'h1E);
        wr(5'd0, 8'h70);
        rd(5'd3, r);
        chk(r == 8'(50 * 5 + 64), "R7 opcode unchanged", r, 8'(50 * 5 + 64));
        rd(5'd8, r);
        chk(r == opv(0, 50), "R7 operand unchanged", r, opv(0, 50));
        rdy_mode = 0;
        while (nlast < 1) @(negedge clk);
        @(negedge clk);
        res_valid = 1; res_ack = 0;
        @(negedge clk);
        res_valid = 0;
        repeat (3) @(negedge clk);
        chk(ncap == 4, "R7 single frame, limit unchanged", ncap, 4);
        chk(cap[1] == 8'(50 * 5 + 64) && cap[2] == opv(0, 50), "R7 old contents sent", cap[1], 8'(50 * 5 + 64));
        chk(busy == 0, "R7 second start ignored", busy, 0);

        // R8 flush aborts
        stage(60, 2);
        rdy_mode = 2;
        ncap = 0; nlast = 0;
        o0 = c_ok; o1 = c_nack; o2 = c_arb;
        wr(5'd4, 8'h12);
        repeat (2) @(negedge clk);
        chk(busy == 1, "R8 frame running before flush", busy, 1);
        wr(5'd0, 8'h80);
        rd(5'd0, r);
        chk(r[7] == 1, "R8 flush bit set", r[7], 1);
        repeat (FLC + 2) @(negedge clk);
        rd(5'd0, r);
        chk(r[7] == 0, "R8 flush bit self-clears", r[7], 0);
        chk(busy == 0 && tx_valid == 0, "R8 frame aborted", busy, 0);
        chk(c_ok == o0 && c_nack == o1 && c_arb == o2, "R8 no event on flush", c_ok + c_nack + c_arb, o0 + o1 + o2);
        rdy_mode = 0;

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule